// File: doc/BRIEF.md
# Fused Compare-and-Branch Resolver

This unit decides whether a compare-and-branch instruction is taken and works out the program counter that follows it. A decode stage presents a 3-bit condition selector, a first operand, a second operand, the current PC, the branch target and a delay-slot flag. The first operand comes from a register value, or from an inline 32-bit literal when the first-operand register index holds the reserved literal code. The second operand comes from a register value or from a 6-bit immediate. The unit returns the taken decision, an illegal-condition flag, the instruction length and the next PC.

The results are captured on a valid strobe and held until the next one. A taken branch that has the delay-slot flag set does not redirect at once. The unit reports the sequential PC and keeps the target. The next strobe, which is the slot instruction, then receives the kept target as its next PC.

Top module: `cbr_eval`

## Requirements
- R1: Selector 0 is taken when the operands are equal. Selector 1 is taken when they differ.
- R2: Selector 2 is taken when A < B and selector 3 when A >= B, with both operands read as two's-complement signed values.
- R3: Selector 4 is taken when A < B and selector 5 when A >= B, with both operands read as unsigned values.
- R4: When `use_imm_i` is 1, operand B is `imm6_i` zero-extended to 32 bits and `reg_b_i` has no effect.
- R5: When `a_idx_i` equals 62, operand A is `limm_i` and the length is 8. For any other index, operand A is `reg_a_i` and the length is 4. Lengths are in bytes on `len_o`.
- R6: A branch that is not taken gives next PC = PC + length.
- R7: A taken branch with `dslot_i` = 0 gives next PC = target.
- R8: A taken branch with `dslot_i` = 1 gives next PC = PC + length, sets `slot_pend_o` and keeps the target. The next strobe gives that kept target as its next PC and clears `slot_pend_o`. A strobe that consumes a kept target never starts a new hold.
- R9: Selectors 6 and 7 set `illegal_o`, are never taken, give next PC = PC + length and start no hold.
- R10: Outputs update only in the cycle after `valid_i` is high. `out_valid_o` is high for exactly that cycle.
- R11: A synchronous active-high reset clears `taken_o`, `illegal_o`, `slot_pend_o`, `out_valid_o`, `dslot_o`, `next_pc_o` and `len_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Strobe that captures a new instruction |
| cond_i | input | 3 | Condition selector |
| a_idx_i | input | 6 | First-operand register index (62 selects the literal) |
| reg_a_i | input | 32 | First operand read from a register |
| limm_i | input | 32 | Inline literal word |
| use_imm_i | input | 1 | Second operand taken from the 6-bit immediate |
| imm6_i | input | 6 | Unsigned immediate |
| reg_b_i | input | 32 | Second operand read from a register |
| pc_i | input | 32 | Current PC |
| target_i | input | 32 | Branch target |
| dslot_i | input | 1 | Delay-slot flag |
| taken_o | output | 1 | Branch taken |
| illegal_o | output | 1 | Reserved selector seen |
| dslot_o | output | 1 | Delay-slot flag of the captured instruction |
| slot_pend_o | output | 1 | A target is kept for the slot instruction |
| len_o | output | 4 | Instruction length in bytes |
| next_pc_o | output | 32 | Next PC |
| out_valid_o | output | 1 | Outputs refreshed this cycle |

## Verification
The stimulus aims at the operand pairs where the signed and unsigned orders disagree: one operand has bit 31 set and the other does not, and the operands are also tried equal. A design that mixes up the two orders, or uses a strict compare where a non-strict one belongs, fails exactly there. The bench also covers immediates at 0 and 63 against register values that hold high bits, to catch sign extension or a wrong operand choice. It covers the literal code against nearby register indices, to catch a length of 4 where 8 is due. Taken delay-slot branches are sent back to back, so that a lost or duplicated kept target shows up as a wrong next PC on the slot instruction.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned IDXW      = 6;
  localparam int unsigned IMMW      = 6;
  localparam int unsigned LENW      = 4;
  localparam logic [IDXW-1:0] LIT_CODE = 6'd62;
  localparam logic [LENW-1:0] LEN_SHORT = 4'd4;
  localparam logic [LENW-1:0] LEN_LONG  = 4'd8;

  typedef enum logic [2:0] {
    C_EQ  = 3'd0,
    C_NE  = 3'd1,
    C_SLT = 3'd2,
    C_SGE = 3'd3,
    C_ULT = 3'd4,
    C_UGE = 3'd5,
    C_RS6 = 3'd6,
    C_RS7 = 3'd7
  } cond_e;

  function automatic logic lt_signed(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  function automatic logic ge_signed(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return $signed(a) >= $signed(b);
  endfunction

  function automatic logic [XLEN-1:0] zext_imm(input logic [IMMW-1:0] u);
    return {{(XLEN-IMMW){1'b0}}, u};
  endfunction
endpackage

// File: rtl/cbr_operands.sv
module cbr_operands
  import cbr_pkg::*;
(
  input  logic [IDXW-1:0] a_idx,
  input  logic [XLEN-1:0] reg_a,
  input  logic [XLEN-1:0] limm,
  input  logic            use_imm,
  input  logic [IMMW-1:0] imm6,
  input  logic [XLEN-1:0] reg_b,
  output logic [XLEN-1:0] opa,
  output logic [XLEN-1:0] opb,
  output logic [LENW-1:0] len
);
  logic lit_sel;
  assign lit_sel = (a_idx == LIT_CODE);
  assign opa = lit_sel ? limm : reg_a;
  assign len = lit_sel ? LEN_LONG : LEN_SHORT;
  assign opb = use_imm ? zext_imm(imm6) : reg_b;
endmodule

// File: rtl/cbr_compare.sv
module cbr_compare
  import cbr_pkg::*;
(
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            hit,
  output logic            reserved
);
  logic eq_w, slt_w, sge_w, ult_w, uge_w;
  assign eq_w  = (opa == opb);
  assign slt_w = lt_signed(opa, opb);
  assign sge_w = ge_signed(opa, opb);
  assign ult_w = (opa < opb);
  assign uge_w = (opa >= opb);

  always_comb begin
    hit      = 1'b0;
    reserved = 1'b0;
    unique case (cond_e'(cond))
      C_EQ:    hit = eq_w;
      C_NE:    hit = !eq_w;
      C_SLT:   hit = slt_w;
      C_SGE:   hit = sge_w;
      C_ULT:   hit = ult_w;
      C_UGE:   hit = uge_w;
      default: reserved = 1'b1;
    endcase
  end

  always_comb begin
    a_r2_signed_split: assert (slt_w != sge_w);
    a_r3_unsigned_split: assert (ult_w != uge_w);
  end
endmodule

// File: rtl/cbr_nextpc.sv
module cbr_nextpc
  import cbr_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic [LENW-1:0] len,
  input  logic [XLEN-1:0] target,
  input  logic            hit,
  input  logic            reserved,
  input  logic            dslot,
  input  logic            pend_q,
  input  logic [XLEN-1:0] kept_q,
  output logic            taken,
  output logic            start_hold,
  output logic [XLEN-1:0] npc
);
  logic [XLEN-1:0] seq_pc;
  assign seq_pc     = pc + {{(XLEN-LENW){1'b0}}, len};
  assign taken      = hit && !reserved;
  assign start_hold = taken && dslot && !pend_q;

  always_comb begin
    if (pend_q)                npc = kept_q;
    else if (taken && !dslot)  npc = target;
    else                       npc = seq_pc;
  end
endmodule

// File: rtl/cbr_eval.sv
module cbr_eval
  import cbr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [2:0]      cond_i,
  input  logic [5:0]      a_idx_i,
  input  logic [31:0]     reg_a_i,
  input  logic [31:0]     limm_i,
  input  logic            use_imm_i,
  input  logic [5:0]      imm6_i,
  input  logic [31:0]     reg_b_i,
  input  logic [31:0]     pc_i,
  input  logic [31:0]     target_i,
  input  logic            dslot_i,
  output logic            taken_o,
  output logic            illegal_o,
  output logic            dslot_o,
  output logic            slot_pend_o,
  output logic [3:0]      len_o,
  output logic [31:0]     next_pc_o,
  output logic            out_valid_o
);
  logic [XLEN-1:0] opa, opb, npc_w, kept_q;
  logic [LENW-1:0] len_w;
  logic hit_w, rsv_w, taken_w, hold_w, pend_q;

  cbr_operands u_ops (
    .a_idx(a_idx_i), .reg_a(reg_a_i), .limm(limm_i), .use_imm(use_imm_i),
    .imm6(imm6_i), .reg_b(reg_b_i), .opa(opa), .opb(opb), .len(len_w)
  );

  cbr_compare u_cmp (
    .cond(cond_i), .opa(opa), .opb(opb), .hit(hit_w), .reserved(rsv_w)
  );

  cbr_nextpc u_npc (
    .pc(pc_i), .len(len_w), .target(target_i), .hit(hit_w), .reserved(rsv_w),
    .dslot(dslot_i), .pend_q(pend_q), .kept_q(kept_q),
    .taken(taken_w), .start_hold(hold_w), .npc(npc_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o     <= 1'b0;
      illegal_o   <= 1'b0;
      dslot_o     <= 1'b0;
      pend_q      <= 1'b0;
      kept_q      <= '0;
      len_o       <= '0;
      next_pc_o   <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= valid_i;
      if (valid_i) begin
        taken_o   <= taken_w;
        illegal_o <= rsv_w;
        dslot_o   <= dslot_i;
        len_o     <= len_w;
        next_pc_o <= npc_w;
        pend_q    <= hold_w;
        if (hold_w) kept_q <= target_i;
      end
    end
  end

  assign slot_pend_o = pend_q;

  a_r9_illegal_not_taken: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!taken_o && !slot_pend_o));
  a_r5_len_legal: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (len_o == LEN_SHORT || len_o == LEN_LONG));
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(next_pc_o) && $stable(taken_o) && !out_valid_o));
  a_r8_hold_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(slot_pend_o) |-> (taken_o && dslot_o));
  a_r8_hold_consumed: assert property (@(posedge clk) disable iff (rst)
    (slot_pend_o && valid_i) |=> !slot_pend_o);
endmodule

// File: tb/tb_cbr_eval.sv
module tb_cbr_eval;
  logic clk = 1'b0, rst = 1'b1, valid_i = 1'b0;
  logic [2:0] cond_i = '0;
  logic [5:0] a_idx_i = '0, imm6_i = '0;
  logic [31:0] reg_a_i = '0, limm_i = '0, reg_b_i = '0, pc_i = '0, target_i = '0;
  logic use_imm_i = 1'b0, dslot_i = 1'b0;
  logic taken_o, illegal_o, dslot_o, slot_pend_o, out_valid_o;
  logic [3:0] len_o;
  logic [31:0] next_pc_o;

  int checks = 0, fails = 0;
  bit m_pend = 0;
  logic [31:0] m_kept = '0;

  cbr_eval dut (.*);

  always #2 clk = ~clk;

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish (got hang, expected completion)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic bit ref_take(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return (a[31] != b[31]) ? a[31] : (a < b);
      3'd3: return (a[31] != b[31]) ? b[31] : (a >= b);
      3'd4: return a < b;
      3'd5: return !(a < b);
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [5:0] idx, input logic [31:0] ra,
                       input logic [31:0] lit, input bit ui, input logic [5:0] u,
                       input logic [31:0] rb, input logic [31:0] pc, input logic [31:0] tg,
                       input bit ds, input string tag);
    logic [31:0] a, b, seq, enpc;
    logic [3:0] elen;
    bit tk, ill, newh;
    a = (idx == 6'd62) ? lit : ra;
    b = ui ? {26'd0, u} : rb;
    elen = (idx == 6'd62) ? 4'd8 : 4'd4;
    ill = (c >= 3'd6);
    tk = ref_take(c, a, b);
    seq = pc + elen;
    if (m_pend) enpc = m_kept;
    else if (tk && !ds) enpc = tg;
    else enpc = seq;
    newh = tk && ds && !m_pend;
    @(negedge clk);
    cond_i = c; a_idx_i = idx; reg_a_i = ra; limm_i = lit; use_imm_i = ui; imm6_i = u;
    reg_b_i = rb; pc_i = pc; target_i = tg; dslot_i = ds; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk({tag, " taken"}, {31'd0, taken_o}, {31'd0, tk});
    chk({tag, " R9 illegal"}, {31'd0, illegal_o}, {31'd0, ill});
    chk({tag, " R5 len"}, {28'd0, len_o}, {28'd0, elen});
    chk({tag, " next_pc"}, next_pc_o, enpc);
    chk({tag, " R8 pend"}, {31'd0, slot_pend_o}, {31'd0, newh});
    chk({tag, " R10 out_valid"}, {31'd0, out_valid_o}, 32'd1);
    if (newh) m_kept = tg;
    m_pend = newh;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R11 reset taken", {31'd0, taken_o}, 0);
    chk("R11 reset illegal", {31'd0, illegal_o}, 0);
    chk("R11 reset pend", {31'd0, slot_pend_o}, 0);
    chk("R11 reset next_pc", next_pc_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 idle out_valid", {31'd0, out_valid_o}, 0);

    issue(3'd0, 6'd3, 32'h1234, 0, 0, 0, 32'h1234, 32'h100, 32'h900, 0, "R1 eq");
    issue(3'd1, 6'd3, 32'h1234, 0, 0, 0, 32'h1234, 32'h100, 32'h900, 0, "R1 ne");
    issue(3'd2, 6'd3, 32'hFFFF_FFFF, 0, 0, 0, 32'h1, 32'h200, 32'h800, 0, "R2 slt neg");
    issue(3'd3, 6'd3, 32'h8000_0000, 0, 0, 0, 32'h7FFF_FFFF, 32'h200, 32'h800, 0, "R2 sge");
    issue(3'd3, 6'd3, 32'h5, 0, 0, 0, 32'h5, 32'h200, 32'h800, 0, "R2 sge equal");
    issue(3'd4, 6'd3, 32'h1, 0, 0, 0, 32'hFFFF_FFFF, 32'h300, 32'h700, 0, "R3 ult");
    issue(3'd5, 6'd3, 32'h8000_0000, 0, 0, 0, 32'h7FFF_FFFF, 32'h300, 32'h700, 0, "R3 uge");
    issue(3'd4, 6'd3, 32'h9, 0, 0, 0, 32'h9, 32'h300, 32'h700, 0, "R3 ult equal");
    issue(3'd0, 6'd3, 32'h3F, 0, 1, 6'd63, 32'hFFFF_FFFF, 32'h400, 32'h40, 0, "R4 imm63");
    issue(3'd2, 6'd3, 32'hFFFF_FFC0, 0, 1, 6'd0, 32'h0, 32'h400, 32'h40, 0, "R4 imm0 signed");
    issue(3'd0, 6'd62, 32'h0, 32'hCAFE, 0, 0, 32'hCAFE, 32'h500, 32'h44, 0, "R5 literal");
    issue(3'd0, 6'd61, 32'h0, 32'hCAFE, 0, 0, 32'hCAFE, 32'h500, 32'h44, 0, "R5 idx61 R6");
    issue(3'd0, 6'd63, 32'hCAFE, 32'h0, 0, 0, 32'hCAFE, 32'h500, 32'h44, 0, "R5 idx63 R7");
    issue(3'd6, 6'd3, 32'h1, 0, 0, 0, 32'h1, 32'h600, 32'h10, 1, "R9 rsv6");
    issue(3'd7, 6'd62, 32'h1, 32'h1, 0, 0, 32'h1, 32'h600, 32'h10, 0, "R9 rsv7");
    issue(3'd1, 6'd3, 32'h1, 0, 0, 0, 32'h2, 32'h700, 32'hA00, 1, "R8 hold start");
    repeat (3) @(negedge clk);
    chk("R10 idle keeps next_pc", next_pc_o, 32'h704);
    chk("R8 pend kept idle", {31'd0, slot_pend_o}, 1);
    issue(3'd1, 6'd3, 32'h1, 0, 0, 0, 32'h2, 32'h704, 32'hB00, 1, "R8 slot consume");
    issue(3'd0, 6'd3, 32'h1, 0, 0, 0, 32'h2, 32'h708, 32'hC00, 0, "R8 after slot R6");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      logic [5:0] idx;
      ra = $urandom;
      case ($urandom_range(0, 3))
        0: rb = ra;
        1: rb = ra ^ 32'h8000_0000;
        2: rb = {1'b0, ra[30:0]} + 1;
        default: rb = $urandom;
      endcase
      idx = ($urandom_range(0, 3) == 0) ? 6'd62 : 6'($urandom);
      issue(3'($urandom), idx, ra, rb, $urandom_range(0, 1) == 1, 6'($urandom), rb,
            $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, $urandom_range(0, 1) == 1,
            "R1 R2 R3 R7 random");
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 re-reset pend", {31'd0, slot_pend_o}, 0);
    chk("R11 re-reset len", {28'd0, len_o}, 0);
    m_pend = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule